// File: doc/BRIEF.md
# Prioritized Interrupt and Exception Dispatcher

This block decides, once per clock, whether the processor leaves normal execution for a privileged handler, and where that handler starts. It takes four asynchronous-style interrupt request lines (device, timer, inter-processor, machine check) and a synchronous exception request with a cause code and an 8-bit call code. Interrupts are masked cumulatively by a 3-bit priority level and are never taken while the processor already runs in privileged mode. A synchronous exception always wins over interrupts arriving in the same cycle.

For the event taken it computes the handler address as a vector base plus an offset. Fixed events have fixed offsets. A call exception has its offset derived from the call code, with separate 64-byte slot regions for privileged and unprivileged calls. It also produces the return address to save, which carries the current privileged-mode flag in bit 0. It produces a one-cycle pulse that tells the core to enter privileged mode.

All results are registered and appear one clock after the inputs that caused them. The first clock after reset is released always yields a reset dispatch to offset zero.

Top module: `exc_dispatch`

## Requirements
- R1: While `rst_n` is low, `disp_valid`, `priv_set` and `bad_cause` are 0. On the first rising clock edge after release, a dispatch occurs regardless of other inputs: `new_pc` = `vec_base`, `saved_pc` = 0, `taken_cause` = 0, `err_code` = 0.
- R2: When `priv_mode_in` is 1 and no exception is requested, no interrupt is dispatched in the following cycle.
- R3: Interrupt eligibility by `ipl`: at 0 to 3 all four lines are eligible. At 4 the device line is masked. At 5 the timer line is also masked. At 6 only machine check is eligible. At 7 nothing is eligible.
- R4: Among eligible requests, the one taken is machine check (`taken_cause` 1, offset 0x080), then inter-processor (2, 0x100), then timer (3, 0x180), then device (4, 0x200).
- R5: Exception cause codes on `exc_cause` and their offsets are: 5 memory fault 0x280, 6 unaligned 0x300, 7 illegal opcode 0x380, 8 arithmetic 0x400, 9 FP-disabled 0x480. `taken_cause` echoes the code.
- R6: Cause code 10 is a call exception. If bit 7 of `call_code` is 1, the offset is 0x2000 + (code − 0x80)·64; otherwise it is 0x1000 + code·64.
- R7: On every non-reset dispatch, `saved_pc` equals the sampled `cur_pc` ORed with `priv_mode_in` in bit 0.
- R8: On every dispatch, `new_pc` equals `vec_base` plus the offset, and `priv_set` is 1 exactly when `disp_valid` is 1.
- R9: `err_code` is 0 for an interrupt dispatch and equals the sampled `call_code` for an exception dispatch.
- R10: An accepted exception request is dispatched even when eligible interrupts are pending in the same cycle, and `priv_mode_in` does not block it.
- R11: An exception request with a cause code outside 5 to 10 raises `bad_cause` for one cycle. Nothing is dispatched for that cycle, and pending interrupts are not taken in it.
- R12: Outputs change one clock after the sampled inputs. A cycle with nothing accepted leaves `disp_valid` and `bad_cause` low next cycle, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | PC_W | Current program counter |
| priv_mode_in | input | 1 | Processor currently in privileged mode |
| ipl | input | IPL_W | Interrupt priority level |
| irq_dev | input | 1 | Device interrupt request |
| irq_timer | input | 1 | Timer interrupt request |
| irq_ipi | input | 1 | Inter-processor interrupt request |
| irq_mchk | input | 1 | Machine-check request |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | 4 | Exception cause code |
| call_code | input | CALL_W | Call-exception code |
| vec_base | input | PC_W | Handler vector base |
| disp_valid | output | 1 | Dispatch pulse |
| new_pc | output | PC_W | Handler entry address |
| saved_pc | output | PC_W | Return address with mode in bit 0 |
| priv_set | output | 1 | Enter privileged mode |
| taken_cause | output | 4 | Code of the dispatched event |
| err_code | output | CALL_W | Error code for the handler |
| bad_cause | output | 1 | Unknown exception cause rejected |

## Verification
The properties assume the inputs are stable around each rising edge. They also assume that each cycle's inputs describe a single request set, sampled once and not held by the block. They treat the first cycle after reset release separately, because that cycle is reserved for the reset dispatch. The stimulus changes inputs only on the falling edge. It mixes directed cases for each level boundary, each call region and each illegal cause with random cycles that hit all 16 cause codes, all eight levels and both mode values. The random cycles also hold requests across consecutive cycles, so back-to-back dispatches occur.

// File: rtl/exc_dispatch_pkg.sv
package exc_dispatch_pkg;

   localparam int CAUSE_W = 4;
   localparam int OFF_W   = 16;

   typedef enum logic [CAUSE_W-1:0] {
      EV_RESET   = 4'd0,
      EV_MCHK    = 4'd1,
      EV_IPI     = 4'd2,
      EV_TIMER   = 4'd3,
      EV_DEVICE  = 4'd4,
      EV_MEMFLT  = 4'd5,
      EV_UNALIGN = 4'd6,
      EV_ILLOP   = 4'd7,
      EV_ARITH   = 4'd8,
      EV_FPOFF   = 4'd9,
      EV_CALL    = 4'd10
   } ev_e;

   localparam logic [CAUSE_W-1:0] EXC_FIRST = EV_MEMFLT;
   localparam logic [CAUSE_W-1:0] EXC_LAST  = EV_CALL;
   localparam int FIXED_STRIDE_LOG2 = 7;

endpackage

// File: rtl/exc_irq_select.sv
module exc_irq_select #(
   parameter int NUM_LINES = 4,
   parameter int IPL_W     = 3,
   parameter int BASE_LVL  = 3,
   localparam int SEL_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic [IPL_W-1:0]     ipl,
   input  logic [NUM_LINES-1:0] req,
   output logic                 any,
   output logic [SEL_W-1:0]     sel
);

   logic [NUM_LINES-1:0] elig;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_mask
      localparam int LIMIT = BASE_LVL + i;
      assign elig[i] = req[i] && (int'(ipl) <= LIMIT);
   end

   always_comb begin
      any = 1'b0;
      sel = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (elig[i]) begin
            any = 1'b1;
            sel = SEL_W'(i);
         end
      end
   end

endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
   import exc_dispatch_pkg::*;
#(
   parameter int          CALL_W         = 8,
   parameter int          SLOT_LOG2      = 6,
   parameter logic [15:0] PRIV_CALL_BASE = 16'h1000,
   parameter logic [15:0] USER_CALL_BASE = 16'h2000
) (
   input  ev_e              ev,
   input  logic [CALL_W-1:0] call_code,
   output logic [OFF_W-1:0]  offset
);

   logic [OFF_W-1:0] slot;
   logic [OFF_W-1:0] fixed_off;

   assign slot      = OFF_W'(call_code[CALL_W-2:0]) << SLOT_LOG2;
   assign fixed_off = OFF_W'(ev) << FIXED_STRIDE_LOG2;

   always_comb begin
      if (ev == EV_CALL) begin
         if (call_code[CALL_W-1]) offset = USER_CALL_BASE + slot;
         else                     offset = PRIV_CALL_BASE + slot;
      end else begin
         offset = fixed_off;
      end
   end

endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
   import exc_dispatch_pkg::*;
#(
   parameter int PC_W      = 64,
   parameter int IPL_W     = 3,
   parameter int CALL_W    = 8,
   parameter int SLOT_LOG2 = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   cur_pc,
   input  logic              priv_mode_in,
   input  logic [IPL_W-1:0]  ipl,
   input  logic              irq_dev,
   input  logic              irq_timer,
   input  logic              irq_ipi,
   input  logic              irq_mchk,
   input  logic              exc_req,
   input  logic [3:0]        exc_cause,
   input  logic [CALL_W-1:0] call_code,
   input  logic [PC_W-1:0]   vec_base,
   output logic              disp_valid,
   output logic [PC_W-1:0]   new_pc,
   output logic [PC_W-1:0]   saved_pc,
   output logic              priv_set,
   output logic [3:0]        taken_cause,
   output logic [CALL_W-1:0] err_code,
   output logic              bad_cause
);

   localparam int NUM_IRQ = 4;
   localparam int SEL_W   = $clog2(NUM_IRQ);

   if (PC_W <= OFF_W) begin : g_chk_pc
      $error("PC_W must exceed the offset width");
   end
   if (IPL_W < 3) begin : g_chk_ipl
      $error("IPL_W must be at least 3");
   end
   if (CALL_W < 2 || CALL_W + SLOT_LOG2 > OFF_W - 2) begin : g_chk_call
      $error("call code and slot size do not fit the offset");
   end

   logic              boot_q;
   logic              irq_any;
   logic [SEL_W-1:0]  irq_sel;
   ev_e               ev_nx;
   logic              take_nx;
   logic              bad_nx;
   logic              exc_ok;
   logic [OFF_W-1:0]  offset;
   logic [CALL_W-1:0] code_nx;
   logic [PC_W-1:0]   saved_nx;

   exc_irq_select #(
      .NUM_LINES (NUM_IRQ),
      .IPL_W     (IPL_W),
      .BASE_LVL  (3)
   ) u_sel (
      .ipl (ipl),
      .req ({irq_mchk, irq_ipi, irq_timer, irq_dev}),
      .any (irq_any),
      .sel (irq_sel)
   );

   exc_vector_calc #(
      .CALL_W    (CALL_W),
      .SLOT_LOG2 (SLOT_LOG2)
   ) u_vec (
      .ev        (ev_nx),
      .call_code (call_code),
      .offset    (offset)
   );

   assign exc_ok = (exc_cause >= EXC_FIRST) && (exc_cause <= EXC_LAST);

   always_comb begin
      ev_nx    = EV_RESET;
      take_nx  = 1'b0;
      bad_nx   = 1'b0;
      code_nx  = '0;
      saved_nx = {cur_pc[PC_W-1:1], cur_pc[0] | priv_mode_in};
      if (boot_q) begin
         take_nx  = 1'b1;
         saved_nx = '0;
      end else if (exc_req) begin
         if (exc_ok) begin
            take_nx = 1'b1;
            ev_nx   = ev_e'(exc_cause);
            code_nx = call_code;
         end else begin
            bad_nx  = 1'b1;
         end
      end else if (!priv_mode_in && irq_any) begin
         take_nx = 1'b1;
         ev_nx   = ev_e'(4'(EV_DEVICE) - 4'(irq_sel));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_q      <= 1'b1;
         disp_valid  <= 1'b0;
         priv_set    <= 1'b0;
         bad_cause   <= 1'b0;
         new_pc      <= '0;
         saved_pc    <= '0;
         taken_cause <= '0;
         err_code    <= '0;
      end else begin
         boot_q     <= 1'b0;
         disp_valid <= take_nx;
         priv_set   <= take_nx;
         bad_cause  <= bad_nx;
         if (take_nx) begin
            new_pc      <= vec_base + PC_W'(offset);
            saved_pc    <= saved_nx;
            taken_cause <= ev_nx;
            err_code    <= code_nx;
         end
      end
   end

endmodule

// File: rtl/exc_dispatch_chk.sv
module exc_dispatch_chk #(
   parameter int PC_W   = 64,
   parameter int IPL_W  = 3,
   parameter int CALL_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PC_W-1:0]   cur_pc,
   input logic              priv_mode_in,
   input logic [IPL_W-1:0]  ipl,
   input logic              irq_dev,
   input logic              irq_timer,
   input logic              irq_ipi,
   input logic              irq_mchk,
   input logic              exc_req,
   input logic [3:0]        exc_cause,
   input logic [CALL_W-1:0] call_code,
   input logic [PC_W-1:0]   vec_base,
   input logic              disp_valid,
   input logic [PC_W-1:0]   new_pc,
   input logic [PC_W-1:0]   saved_pc,
   input logic              priv_set,
   input logic [3:0]        taken_cause,
   input logic [CALL_W-1:0] err_code,
   input logic              bad_cause
);

   logic boot;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) boot <= 1'b1;
      else        boot <= 1'b0;
   end

   p_priv_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!boot && !exc_req && priv_mode_in) |=> !disp_valid);

   p_level7_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!boot && !exc_req && ipl == 3'd7) |=> !disp_valid);

   p_level6_mchk_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!boot && !exc_req && ipl == 3'd6 && !irq_mchk) |=> !disp_valid);

   p_mchk_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!boot && !exc_req && !priv_mode_in && irq_mchk && ipl <= 3'd6)
      |=> (disp_valid && taken_cause == 4'd1));

   p_saved_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!boot && exc_req && exc_cause >= 4'd5 && exc_cause <= 4'd10)
      |=> (saved_pc == ($past(cur_pc) | PC_W'($past(priv_mode_in)))));

   p_priv_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      priv_set == disp_valid);

   p_irq_code_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && taken_cause >= 4'd1 && taken_cause <= 4'd4) |-> err_code == '0);

   p_exc_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!boot && exc_req && exc_cause >= 4'd5 && exc_cause <= 4'd10)
      |=> (disp_valid && taken_cause == $past(exc_cause)));

   p_bad_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!boot && exc_req && (exc_cause < 4'd5 || exc_cause > 4'd10))
      |=> (bad_cause && !disp_valid));

   p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({disp_valid, bad_cause}));

endmodule

bind exc_dispatch exc_dispatch_chk #(
   .PC_W   (PC_W),
   .IPL_W  (IPL_W),
   .CALL_W (CALL_W)
) u_chk (.*);

// File: tb/test_exc_dispatch.sv
module test_exc_dispatch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cur_pc = '0;
   logic        priv_mode_in = 1'b0;
   logic [2:0]  ipl = '0;
   logic        irq_dev = 1'b0, irq_timer = 1'b0, irq_ipi = 1'b0, irq_mchk = 1'b0;
   logic        exc_req = 1'b0;
   logic [3:0]  exc_cause = '0;
   logic [7:0]  call_code = '0;
   logic [63:0] vec_base = '0;
   logic        disp_valid, priv_set, bad_cause;
   logic [63:0] new_pc, saved_pc;
   logic [3:0]  taken_cause;
   logic [7:0]  err_code;

   always #10 clk = ~clk;

   exc_dispatch i_exc_dispatch (.*);

   int vectors = 0;
   int miscompares = 0;
   bit have_exp = 0;
   bit boot = 0;
   bit          e_valid, e_bad;
   logic [63:0] e_pc, e_saved;
   int          e_cause;
   logic [7:0]  e_code;
   string       e_tag;

   function automatic int fixed_off(int c);
      case (c)
         0: return 'h000;  1: return 'h080;  2: return 'h100;
         3: return 'h180;  4: return 'h200;  5: return 'h280;
         6: return 'h300;  7: return 'h380;  8: return 'h400;
         default: return 'h480;
      endcase
   endfunction

   // Reference: computes what the next clock should produce from the
   // inputs now driven (R1..R11).
   task automatic predict();
      int off;
      e_valid = 0; e_bad = 0; e_cause = 0; e_code = '0; e_saved = '0; e_pc = '0;
      if (boot) begin
         e_valid = 1; e_pc = vec_base; e_tag = "R1";
      end else if (exc_req) begin
         if (exc_cause >= 5 && exc_cause <= 10) begin
            if (exc_cause == 10) begin
               off = (call_code >= 8'h80) ? 'h2000 + (int'(call_code) - 'h80) * 64
                                         : 'h1000 + int'(call_code) * 64;
               e_tag = "R6";
            end else begin
               off = fixed_off(int'(exc_cause));
               e_tag = "R5";
            end
            e_valid = 1; e_cause = exc_cause; e_code = call_code;
            e_pc = vec_base + 64'(off);
            e_saved = cur_pc | 64'(priv_mode_in);
         end else begin
            e_bad = 1; e_tag = "R11";
         end
      end else if (priv_mode_in) begin
         e_tag = "R2";
      end else begin
         e_tag = "R3";
         if      (irq_mchk  && ipl <= 6) e_cause = 1;
         else if (irq_ipi   && ipl <= 5) e_cause = 2;
         else if (irq_timer && ipl <= 4) e_cause = 3;
         else if (irq_dev   && ipl <= 3) e_cause = 4;
         if (e_cause != 0) begin
            e_valid = 1; e_tag = "R4";
            e_pc = vec_base + 64'(fixed_off(e_cause));
            e_saved = cur_pc | 64'(priv_mode_in);
         end
      end
      boot = 0;
   endtask

   task automatic compare();
      bit bad;
      vectors++;
      bad = (disp_valid !== e_valid) || (bad_cause !== e_bad) || (priv_set !== e_valid);
      if (e_valid && !bad)
         bad = (new_pc !== e_pc) || (saved_pc !== e_saved) ||
               (int'(taken_cause) != e_cause) || (err_code !== e_code);
      if (bad) begin
         miscompares++;
         $display("FAIL %s: got v=%0d b=%0d p=%0d pc=%h sv=%h c=%0d e=%h, exp v=%0d b=%0d pc=%h sv=%h c=%0d e=%h",
                  e_tag, disp_valid, bad_cause, priv_set, new_pc, saved_pc, taken_cause, err_code,
                  e_valid, e_bad, e_pc, e_saved, e_cause, e_code);
      end
   endtask

   task automatic step(bit pv, int lvl, bit [3:0] irqs, bit ex, int cause, int cc,
                       logic [63:0] pc, logic [63:0] base);
      @(negedge clk);
      if (have_exp) compare();
      priv_mode_in = pv; ipl = 3'(lvl);
      {irq_mchk, irq_ipi, irq_timer, irq_dev} = irqs;
      exc_req = ex; exc_cause = 4'(cause); call_code = 8'(cc);
      cur_pc = pc; vec_base = base;
      predict();
      have_exp = 1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL R12: watchdog expired, got hang, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [63:0] B;
      B = 64'h0000_0000_0040_0000;
      vec_base = B;
      repeat (3) @(negedge clk);
      // R1: reset state
      vectors++;
      if (disp_valid !== 1'b0 || priv_set !== 1'b0 || bad_cause !== 1'b0) begin
         miscompares++;
         $display("FAIL R1: got v=%0d p=%0d b=%0d, exp 0 0 0", disp_valid, priv_set, bad_cause);
      end
      @(negedge clk);
      rst_n = 1'b1;
      boot = 1;
      predict();          // R1: reset dispatch on first edge
      have_exp = 1;
      // R3 level boundaries for each line, R4 priority
      for (int l = 0; l < 8; l++) begin
         step(0, l, 4'b0001, 0, 0, 0, 64'h1000, B);
         step(0, l, 4'b0010, 0, 0, 0, 64'h1004, B);
         step(0, l, 4'b0100, 0, 0, 0, 64'h1008, B);
         step(0, l, 4'b1000, 0, 0, 0, 64'h100c, B);
         step(0, l, 4'b1111, 0, 0, 0, 64'h1010, B);
         step(0, l, 4'b0111, 0, 0, 0, 64'h1014, B);
      end
      // R2 privileged mode blocks interrupts
      step(1, 0, 4'b1111, 0, 0, 0, 64'h2000, B);
      step(0, 0, 4'b0000, 0, 0, 0, 64'h2000, B);
      // R5 each fixed exception, R7 saved address with mode bit, R9 code
      for (int c = 5; c < 10; c++) step(c[0], 0, 4'b0000, 1, c, 8'h5a, 64'h3000 + 64'(c*4), B);
      // R6 call code regions and edges
      step(0, 7, 4'b0000, 1, 10, 8'h00, 64'h4000, B);
      step(0, 7, 4'b0000, 1, 10, 8'h3f, 64'h4004, B);
      step(1, 7, 4'b0000, 1, 10, 8'h7f, 64'h4008, B);
      step(0, 7, 4'b0000, 1, 10, 8'h80, 64'h400c, B);
      step(1, 7, 4'b0000, 1, 10, 8'hff, 64'h4010, B);
      // R10 exception beats interrupts, also in privileged mode
      step(0, 0, 4'b1111, 1, 8, 8'h11, 64'h5000, B);
      step(1, 0, 4'b1111, 1, 6, 8'h22, 64'h5004, B);
      // R11 unknown causes, pending interrupt not taken that cycle
      for (int c = 0; c < 5; c++) step(0, 0, 4'b1111, 1, c, 0, 64'h6000, B);
      for (int c = 11; c < 16; c++) step(0, 0, 4'b1000, 1, c, 0, 64'h6004, B);
      // R8 different vector base; R12 back-to-back and idle
      step(0, 0, 4'b0100, 0, 0, 0, 64'h7000, 64'hffff_ffff_ffff_0000);
      step(0, 0, 4'b0100, 0, 0, 0, 64'h7004, 64'hffff_ffff_ffff_0000);
      step(0, 0, 4'b0000, 0, 0, 0, 64'h7008, B);
      // random mix covering all requirements
      for (int n = 0; n < 400; n++) begin
         step(bit'($urandom_range(0, 2) == 0), $urandom_range(0, 7), 4'($urandom),
              bit'($urandom_range(0, 3) == 0), $urandom_range(0, 15), $urandom_range(0, 255),
              {$urandom, $urandom}, {$urandom, $urandom_range(0, 65535) << 16});
      end
      @(negedge clk);
      compare();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule